// File: doc/BRIEF.md
# Peripheral Request Router and Priority Channel Arbiter

This block sits between a bank of peripheral request lines and a set of DMA channels. Every request line has its own map register. The register holds a valid flag and a target channel number. A line whose flag is set drives the request input of its chosen channel, and a line whose flag is clear drives nothing. The same register port also returns a summary word with one bit per channel, and that bit is set while the channel raises an interrupt.

A second function decides which channel uses the shared memory master next. Channels fall into four fixed priority levels, taken from bits 3:2 of the channel index. The arbiter always serves the lowest-numbered level that has a channel wanting the master. Inside that level it rotates round-robin, starting after the channel it last granted in that same level. A grant stays in place until the granted channel reports that its burst is complete.

The arbiter is a two-state machine. ARB_IDLE waits for work: the transition "wait" stays in ARB_IDLE when no channel wants the master, and the transition "win" moves to ARB_OWN and records the chosen owner. ARB_OWN drives the one-hot grant: the transition "hold" keeps it there until the owner's burst-complete pulse, and the transition "release" then returns to ARB_IDLE.

Top module: `dreq_route_arb`

## Requirements
- R1: A write to a map register stores write-data bit 7 as the valid flag and bits 4:0 as the target channel. A read of that register returns those two fields in the same positions, with every other bit zero.
- R2: The map register of line i (i < 64) is at byte address 0x100 + 4*i. The map register of line i (i >= 64) is at 0x1100 + 4*(i - 64). A write to any address that selects neither a map register nor the summary word changes no register, and a read of such an address returns zero.
- R3: After reset every map register reads zero, no channel request is driven, and no grant is asserted.
- R4: A request line whose valid flag is set drives the channel request output at its target channel index in the same cycle. A line whose valid flag is clear drives no channel request.
- R5: When several valid lines target the same channel, that channel's request is the OR of those lines.
- R6: A read of address 0x0F0 returns the per-channel interrupt inputs, with bit c belonging to channel c. Writes to 0x0F0 have no effect.
- R7: The priority level of channel c is bits 3:2 of c, and level 0 is the highest. In the idle state the arbiter grants a wanting channel from the highest level that has one, and the grant appears on the clock edge after the want is seen. With no want, no grant is given.
- R8: Within a level, the choice is the first wanting channel of that level in ascending index order, wrapping around, that starts after the channel last granted in that level. After reset the search in every level starts from channel 0.
- R9: Once a grant is given it holds unchanged, whatever the want inputs do and whatever other channels signal as burst complete, until the owner signals burst complete.
- R10: When the owner signals burst complete, the grant drops at the next edge, and a new arbitration is made at the edge after that.
- R11: The grant output is one-hot while a grant is held and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (16) | Register byte address |
| reg_wdata | input | REG_DW (32) | Register write data |
| reg_rdata | output | REG_DW (32) | Register read data, combinational from reg_addr |
| ch_irq | input | NUM_CH (32) | Per-channel interrupt pending |
| periph_req | input | NUM_REQ (72) | Peripheral request lines |
| ch_req | output | NUM_CH (32) | Routed request per channel |
| ch_want | input | NUM_CH (32) | Channel wants the memory master |
| ch_done | input | NUM_CH (32) | Channel burst complete pulse |
| grant | output | NUM_CH (32) | One-hot memory master grant |

## Verification
The assertions assume that a channel's burst-complete pulse matters only while that channel holds the grant. They also assume that want inputs are sampled only in the idle state, so any want pattern is legal at any time. The bench drives the want and done inputs between edges. It raises burst complete on every non-owner channel and drops the owner's want during a hold, which keeps the stimulus inside these rules while still testing that the grant is stable. It clears all wants together with the release pulse, so that the idle cycle after a release arbitrates on a known pattern. The register port is exercised only with full-word writes, and each write lasts exactly one cycle.

// File: rtl/dreq_pkg.sv
`timescale 1ns/1ps
package dreq_pkg;

    localparam int unsigned CHAN_FIELD_W = 5;
    localparam int unsigned MAP_VALID_BIT = 7;
    localparam int unsigned LOW_WINDOW_LINES = 64;
    localparam logic [15:0] MAP_LOW_BASE = 16'h0100;
    localparam logic [15:0] MAP_HIGH_BASE = 16'h1100;
    localparam logic [15:0] IRQ_SUMMARY_ADDR = 16'h00F0;
    localparam int unsigned NUM_LEVELS = 4;

    typedef struct packed {
        logic                    valid;
        logic [CHAN_FIELD_W-1:0] chan;
    } map_entry_t;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_OWN  = 1'b1
    } arb_state_e;

    function automatic logic [15:0] map_addr(input int line);
        if (line < int'(LOW_WINDOW_LINES))
            return MAP_LOW_BASE + 16'(4 * line);
        else
            return MAP_HIGH_BASE + 16'(4 * (line - int'(LOW_WINDOW_LINES)));
    endfunction

    function automatic logic [1:0] prio_level(input int chan);
        return 2'((chan % 16) / 4);
    endfunction

endpackage

// File: rtl/dreq_map_regs.sv
`timescale 1ns/1ps
module dreq_map_regs
    import dreq_pkg::*;
#(
    parameter int unsigned NUM_REQ = 72,
    parameter int unsigned NUM_CH  = 32,
    parameter int unsigned REG_AW  = 16,
    parameter int unsigned REG_DW  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wen,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [REG_DW-1:0]             reg_wdata,
    output logic [REG_DW-1:0]             reg_rdata,
    input  logic [NUM_CH-1:0]             ch_irq,
    output map_entry_t [NUM_REQ-1:0]      map_q
);

    logic [NUM_REQ-1:0] line_sel;
    logic               sum_sel;
    logic               unused_wbits;

    assign unused_wbits = ^{reg_wdata[REG_DW-1:MAP_VALID_BIT+1],
                            reg_wdata[MAP_VALID_BIT-1:CHAN_FIELD_W]};

    assign sum_sel = (reg_addr == REG_AW'(IRQ_SUMMARY_ADDR));

    always_comb begin
        for (int i = 0; i < int'(NUM_REQ); i++) begin
            line_sel[i] = (reg_addr == REG_AW'(map_addr(i)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (reg_wen) begin
            for (int i = 0; i < int'(NUM_REQ); i++) begin
                if (line_sel[i]) begin
                    map_q[i].valid <= reg_wdata[MAP_VALID_BIT];
                    map_q[i].chan  <= reg_wdata[CHAN_FIELD_W-1:0];
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sum_sel) begin
            reg_rdata[NUM_CH-1:0] = ch_irq;
        end
        for (int i = 0; i < int'(NUM_REQ); i++) begin
            if (line_sel[i]) begin
                reg_rdata[MAP_VALID_BIT]    = map_q[i].valid;
                reg_rdata[CHAN_FIELD_W-1:0] = map_q[i].chan;
            end
        end
    end

endmodule

// File: rtl/dreq_router.sv
`timescale 1ns/1ps
module dreq_router
    import dreq_pkg::*;
#(
    parameter int unsigned NUM_REQ = 72,
    parameter int unsigned NUM_CH  = 32
) (
    input  map_entry_t [NUM_REQ-1:0] map_q,
    input  logic [NUM_REQ-1:0]       periph_req,
    output logic [NUM_CH-1:0]        ch_req
);

    always_comb begin
        ch_req = '0;
        for (int c = 0; c < int'(NUM_CH); c++) begin
            for (int l = 0; l < int'(NUM_REQ); l++) begin
                if (periph_req[l] && map_q[l].valid &&
                    (int'(map_q[l].chan) == c)) begin
                    ch_req[c] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dreq_chan_arb.sv
`timescale 1ns/1ps
module dreq_chan_arb
    import dreq_pkg::*;
#(
    parameter int unsigned NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_want,
    input  logic [NUM_CH-1:0] ch_done,
    output logic [NUM_CH-1:0] grant
);

    localparam int unsigned CW = $clog2(NUM_CH);

    arb_state_e                     state_q, state_d;
    logic [CW-1:0]                  owner_q;
    logic [NUM_LEVELS-1:0][CW-1:0]  last_q;

    logic          found;
    logic [CW-1:0] pick_ch;
    logic [1:0]    pick_lvl;

    always_comb begin
        int c;
        found    = 1'b0;
        pick_ch  = '0;
        pick_lvl = '0;
        for (int lv = 0; lv < int'(NUM_LEVELS); lv++) begin
            for (int off = 1; off <= int'(NUM_CH); off++) begin
                c = int'(last_q[lv]) + off;
                if (c >= int'(NUM_CH)) c = c - int'(NUM_CH);
                if (!found && ch_want[c] && (int'(prio_level(c)) == lv)) begin
                    found    = 1'b1;
                    pick_ch  = c[CW-1:0];
                    pick_lvl = 2'(lv);
                end
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (found)            state_d = ARB_OWN;
            ARB_OWN:  if (ch_done[owner_q]) state_d = ARB_IDLE;
            default:                        state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
            last_q  <= {NUM_LEVELS{CW'(NUM_CH - 1)}};
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && found) begin
                owner_q          <= pick_ch;
                last_q[pick_lvl] <= pick_ch;
            end
        end
    end

    always_comb begin
        grant = '0;
        unique case (state_q)
            ARB_IDLE: grant = '0;
            ARB_OWN:  grant[owner_q] = 1'b1;
            default:  grant = '0;
        endcase
    end

endmodule

// File: rtl/dreq_route_arb.sv
`timescale 1ns/1ps
module dreq_route_arb
    import dreq_pkg::*;
#(
    parameter int unsigned NUM_REQ = 72,
    parameter int unsigned NUM_CH  = 32,
    parameter int unsigned REG_AW  = 16,
    parameter int unsigned REG_DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] ch_irq,
    input  logic [NUM_REQ-1:0] periph_req,
    output logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_want,
    input  logic [NUM_CH-1:0] ch_done,
    output logic [NUM_CH-1:0] grant
);

    map_entry_t [NUM_REQ-1:0] map_q;

    dreq_map_regs #(
        .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .REG_AW(REG_AW), .REG_DW(REG_DW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_irq(ch_irq),
        .map_q(map_q)
    );

    dreq_router #(
        .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)
    ) route_i (
        .map_q(map_q), .periph_req(periph_req), .ch_req(ch_req)
    );

    dreq_chan_arb #(
        .NUM_CH(NUM_CH)
    ) arb_i (
        .clk(clk), .rst_n(rst_n), .ch_want(ch_want), .ch_done(ch_done),
        .grant(grant)
    );

endmodule

// File: rtl/dreq_route_arb_chk.sv
`timescale 1ns/1ps
module dreq_route_arb_chk #(
    parameter int unsigned NUM_REQ = 72,
    parameter int unsigned NUM_CH  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] periph_req,
    input logic [NUM_CH-1:0]  ch_req,
    input logic [NUM_CH-1:0]  ch_want,
    input logic [NUM_CH-1:0]  ch_done,
    input logic [NUM_CH-1:0]  grant
);

    a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r9_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && (grant & ch_done) == '0) |=> grant == $past(grant));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ch_done) != '0) |=> grant == '0);

    a_r7_grant_wanted: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && ch_want != '0) |=> (grant & $past(ch_want)) != '0);

    a_r7_no_want_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && ch_want == '0) |=> grant == '0);

    a_r4_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_req == '0) |-> ch_req == '0);

endmodule

bind dreq_route_arb dreq_route_arb_chk #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)
) chk_i (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .ch_req(ch_req),
    .ch_want(ch_want), .ch_done(ch_done), .grant(grant)
);

// File: tb/dreq_route_arb_tb.sv
`timescale 1ns/1ps
module dreq_route_arb_tb_top;

    localparam int NREQ = 72;
    localparam int NCH  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wen = 1'b0;
    logic [15:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH-1:0]  ch_irq = '0;
    logic [NREQ-1:0] periph_req = '0;
    logic [NCH-1:0]  ch_req;
    logic [NCH-1:0]  ch_want = '0;
    logic [NCH-1:0]  ch_done = '0;
    logic [NCH-1:0]  grant;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 0;
    int  last_g[4];
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    dreq_route_arb #(.NUM_REQ(NREQ), .NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_irq(ch_irq),
        .periph_req(periph_req), .ch_req(ch_req), .ch_want(ch_want),
        .ch_done(ch_done), .grant(grant)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] line_addr(input int i);
        return (i < 64) ? 16'(256 + 4 * i) : 16'(4352 + 4 * (i - 64));
    endfunction

    function automatic int line_chan(input int i);
        return (i * 7 + 3) % 32;
    endfunction

    function automatic logic [31:0] next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic int model_pick(input logic [31:0] m);
        for (int lv = 0; lv < 4; lv++)
            for (int off = 1; off <= NCH; off++) begin
                int c;
                c = (last_g[lv] + off) % NCH;
                if (m[c] && ((c % 16) / 4) == lv) return c;
            end
        return -1;
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic arb_round(input logic [31:0] m);
        int e;
        logic [31:0] eg;
        @(negedge clk);
        ch_want = m; ch_done = '0;
        @(negedge clk);
        e = model_pick(m);
        if (e < 0) begin
            chk(grant == '0, "R7 no want gives no grant", grant, 32'h0);
            ch_want = '0;
            return;
        end
        eg = 32'h1 << e;
        chk(grant == eg, "R7 R8 arbitration choice", grant, eg);
        last_g[(e % 16) / 4] = e;
        ch_done = ~eg;
        ch_want = m & ~eg;
        @(negedge clk);
        chk(grant == eg, "R9 grant held", grant, eg);
        ch_done = eg;
        ch_want = '0;
        @(negedge clk);
        chk(grant == '0, "R10 release after done", grant, 32'h0);
        ch_done = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int l = 0; l < 4; l++) last_g[l] = NCH - 1;

        repeat (3) @(negedge clk);
        chk(grant == '0, "R3 grant in reset", grant, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state of the map and routing
        for (int i = 0; i < NREQ; i++) begin
            rd(line_addr(i), d);
            chk(d == 32'h0, "R3 map reads zero", d, 32'h0);
        end
        periph_req = '1;
        #1;
        chk(ch_req == '0, "R3 no routed request", ch_req, 32'h0);
        periph_req = '0;

        // R1 R2 program every line with junk in unused bits
        for (int i = 0; i < NREQ; i++)
            wr(line_addr(i), 32'hFFFF_FF60 | 32'h80 | 32'(line_chan(i)));
        for (int i = 0; i < NREQ; i++) begin
            rd(line_addr(i), d);
            chk(d == (32'h80 | 32'(line_chan(i))), "R1 R2 map readback", d,
                32'h80 | 32'(line_chan(i)));
        end

        // R2 writes to unmapped addresses change nothing and read zero
        wr(16'h1120, 32'h0000_0085);
        wr(16'h0200, 32'h0000_0085);
        wr(16'h0102, 32'h0000_0085);
        wr(16'h1000, 32'h0000_0085);
        rd(16'h1120, d); chk(d == 32'h0, "R2 unmapped read", d, 32'h0);
        rd(16'h0200, d); chk(d == 32'h0, "R2 unmapped read", d, 32'h0);
        rd(16'h0102, d); chk(d == 32'h0, "R2 unmapped read", d, 32'h0);
        for (int i = 0; i < NREQ; i++) begin
            rd(line_addr(i), d);
            chk(d == (32'h80 | 32'(line_chan(i))), "R2 map untouched", d,
                32'h80 | 32'(line_chan(i)));
        end

        // R4 routing of each valid line
        for (int i = 0; i < NREQ; i++) begin
            periph_req = NREQ'(1) << i;
            #1;
            chk(ch_req == (32'h1 << line_chan(i)), "R4 routed line", ch_req,
                32'h1 << line_chan(i));
        end
        periph_req = '0;

        // R4 clearing the valid flag stops routing
        for (int i = 0; i < NREQ; i++) wr(line_addr(i), 32'(line_chan(i)));
        for (int i = 0; i < NREQ; i++) begin
            periph_req = NREQ'(1) << i;
            #1;
            chk(ch_req == '0, "R4 invalid line silent", ch_req, 32'h0);
        end
        periph_req = '0;

        // R5 two lines on one channel are ORed
        wr(line_addr(5), 32'h89);
        wr(line_addr(70), 32'h89);
        periph_req = NREQ'(1) << 5;  #1;
        chk(ch_req == 32'h200, "R5 first line alone", ch_req, 32'h200);
        periph_req = NREQ'(1) << 70; #1;
        chk(ch_req == 32'h200, "R5 second line alone", ch_req, 32'h200);
        periph_req = (NREQ'(1) << 70) | (NREQ'(1) << 5); #1;
        chk(ch_req == 32'h200, "R5 both lines", ch_req, 32'h200);
        periph_req = '0;

        // R6 interrupt summary
        for (int k = 0; k < 8; k++) begin
            ch_irq = next_rng();
            rd(16'h00F0, d);
            chk(d == ch_irq, "R6 summary read", d, ch_irq);
        end
        wr(16'h00F0, 32'hFFFF_FFFF);
        ch_irq = '0;
        rd(16'h00F0, d);
        chk(d == 32'h0, "R6 summary write ignored", d, 32'h0);

        // R7 R8 R9 R10 arbitration
        for (int k = 0; k < 9; k++) arb_round(32'hFFFF_FFFF);
        arb_round(32'hF0F0_F0F0);
        arb_round(32'h0000_0000);
        arb_round(32'h8000_0000);
        arb_round(32'h0001_0001);
        arb_round(32'h0001_0001);
        arb_round(32'h0001_0001);
        for (int k = 0; k < 400; k++) begin
            logic [31:0] m;
            m = next_rng();
            if (k % 3 == 1) m = m & next_rng() & next_rng();
            arb_round(m);
        end

        // R10 a held want is granted one edge after the idle cycle
        @(negedge clk);
        ch_want = 32'h0000_0100;
        @(negedge clk);
        chk(grant == 32'h100, "R7 grant after want", grant, 32'h100);
        ch_done = 32'h100;
        @(negedge clk);
        ch_done = '0;
        chk(grant == '0, "R10 idle cycle after done", grant, 32'h0);
        @(negedge clk);
        chk(grant == 32'h100, "R10 rearbitrate next edge", grant, 32'h100);
        ch_done = 32'h100; ch_want = '0;
        @(negedge clk);
        ch_done = '0;

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule